// File: doc/BRIEF.md
# Magic-Kick Watchdog Timer

This block is a watchdog timer on a simple 32-bit register bus. Software chooses a timeout that is a power of two, given by a 5-bit exponent, and sets an enable bit. To keep the system alive, software must write two fixed key words, in order, to two separate service registers. If the period runs out, if the service sequence is wrong, or if software writes the reset command register, the block sends a one-cycle reset request to the system reset logic.

The block records why the last reset request was raised. This record survives the system reset that the request itself causes. Only the external hard reset clears it. Software reads the record back through the first service register. A user reset input also resets the block and logs its own code. Once the watchdog is running, clearing the enable bit does not stop it straight away. The counter keeps running until a valid service pair completes after the enable bit was cleared.

Top module: `wdg_magic_kick`

## Requirements
- R1: Register offsets are 0x0 (reset command), 0x4 (config: enable in bit 31, exponent in bits 4:0) and 0x8 (service A). Service B is at 0xC. Config reads back enable and exponent with all other bits zero. Service A reads back the cause code in bits 2:0 and zero elsewhere. After hard reset, config reads 0.
- R2: Writing config with bit 31 set while the watchdog is stopped starts the counter from zero with the written exponent d. If no valid service follows, rst_req goes high exactly 2^(d+1) clock edges after the enabling write edge. It stays high for one cycle only, the cause becomes 1, and the counter restarts.
- R3: A valid service restarts the period. A valid service is 0xABCD1234 written to service A, followed by 0x4321DCBA written to service B. The next expiry comes 2^(d+1) edges after the service B write edge.
- R4: A kick fault raises rst_req on the next cycle with cause 2. A kick fault is one of these: service A written with any word other than its key, service B written without a correct service A write just before it, or service B written with a wrong word. The sequence state clears after every service B write.
- R5: Clearing the enable bit while running does not stop the counter. The watchdog still expires on schedule. It stops at the first valid service pair completed after the clear.
- R6: Writing the reset command register with bit 0 set raises rst_req on the next cycle with cause 3. Writing it with bit 0 clear has no effect.
- R7: A new exponent written while the watchdog is running does not change the period in progress. It applies from the next restart, and an expiry counts as a restart.
- R8: The cause code is 0 after hard reset. A user reset (user_rst_n low) sets it to 4. A system reset (sys_rst_n low) clears config and counter but keeps the cause. The cause changes at no other time than when rst_req is raised.
- R9: While the watchdog is stopped, no timeout request is ever raised.
- R10: If a service B write completes a valid pair on the very edge the period would expire, the expiry is cancelled. If the write on that edge is a kick fault, the logged cause is 2, not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| hard_rst_n | input | 1 | Asynchronous hard reset, active low; clears everything including the cause |
| sys_rst_n | input | 1 | Synchronous system reset, active low; keeps the cause |
| user_rst_n | input | 1 | Synchronous user reset, active low; logs cause 4 |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, used together with bus_sel |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The counter, the active exponent and the running flag are not visible through a register read. A fault in any of them therefore shows up only as a reset pulse that comes too early, too late or not at all. Each period check counts edges from the enabling or servicing write, and samples rst_req on the cycle before the expected pulse and on the cycle of the pulse. An off-by-one error in the period, or an exponent that takes effect too soon, becomes visible within one period. A sequencer flag left set appears as a missing cause-2 pulse on the very next lone service B write. A cause register that a system reset wrongly clears is caught by the next read of service A.

// File: rtl/wdg_magic_kick.sv
module wdg_magic_kick #(
  parameter int          DW     = 32,
  parameter int          AW     = 4,
  parameter int          DLY_W  = 5,
  parameter int          EN_BIT = 31,
  parameter logic [31:0] KEY_A  = 32'hABCD1234,
  parameter logic [31:0] KEY_B  = 32'h4321DCBA
) (
  input  logic          clk,
  input  logic          hard_rst_n,
  input  logic          sys_rst_n,
  input  logic          user_rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          rst_req
);
  localparam int CNT_W = (1 << DLY_W) + 1;
  localparam logic [CNT_W-1:0] ONE = 1;
  localparam logic [AW-1:0] A_CMD = 0, A_CFG = 4, A_SVA = 8, A_SVB = 12;
  localparam logic [2:0] C_TMO = 3'd1, C_KICK = 3'd2, C_SOFT = 3'd3, C_USER = 3'd4;

  logic             cfg_en, running, armed;
  logic [DLY_W-1:0] cfg_dly, act_dly;
  logic [CNT_W-1:0] cnt, lim;
  logic [2:0]       cause;

  wire wr      = bus_sel & bus_wr;
  wire wr_cmd  = wr && bus_addr == A_CMD && bus_wdata[0];
  wire wr_cfg  = wr && bus_addr == A_CFG;
  wire wr_sva  = wr && bus_addr == A_SVA;
  wire wr_svb  = wr && bus_addr == A_SVB;
  wire sva_bad = wr_sva && bus_wdata != KEY_A;
  wire svb_ok  = wr_svb && armed && bus_wdata == KEY_B;
  wire kick_bad = sva_bad | (wr_svb & ~svb_ok);
  wire start   = wr_cfg && bus_wdata[EN_BIT] && !running;

  assign lim = ((ONE << act_dly) << 1) - ONE;

  wire expire  = running && cnt == lim && !svb_ok;
  wire issue   = !rst_req && (wr_cmd || kick_bad || expire);
  wire restart = svb_ok || expire || start;
  wire [2:0] new_cause = wr_cmd ? C_SOFT : (kick_bad ? C_KICK : C_TMO);

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      cfg_en <= 1'b0; cfg_dly <= '0; act_dly <= '0; running <= 1'b0;
      armed <= 1'b0; cnt <= '0; rst_req <= 1'b0; cause <= '0;
    end else if (!sys_rst_n || !user_rst_n) begin
      cfg_en <= 1'b0; cfg_dly <= '0; act_dly <= '0; running <= 1'b0;
      armed <= 1'b0; cnt <= '0; rst_req <= 1'b0;
      if (!user_rst_n) cause <= C_USER;
    end else begin
      rst_req <= issue;
      if (issue) cause <= new_cause;
      if (wr_cfg) begin
        cfg_en  <= bus_wdata[EN_BIT];
        cfg_dly <= bus_wdata[DLY_W-1:0];
      end
      if (wr_sva)      armed <= !sva_bad;
      else if (wr_svb) armed <= 1'b0;
      if (wr_cfg && bus_wdata[EN_BIT]) running <= 1'b1;
      else if (svb_ok && !cfg_en)      running <= 1'b0;
      if (restart) begin
        act_dly <= start ? bus_wdata[DLY_W-1:0] : cfg_dly;
        cnt     <= '0;
      end else if (running) begin
        cnt <= cnt + ONE;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG: begin
        bus_rdata[EN_BIT]    = cfg_en;
        bus_rdata[DLY_W-1:0] = cfg_dly;
      end
      A_SVA:   bus_rdata[2:0] = cause;
      default: bus_rdata = '0;
    endcase
  end

  wire quiet = hard_rst_n & sys_rst_n & user_rst_n;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!quiet)
    rst_req |=> !rst_req); // R2
  AST_SOFT_REQ: assert property (@(posedge clk) disable iff (!quiet)
    (wr_cmd && !rst_req) |=> (rst_req && cause == C_SOFT)); // R6
  AST_BAD_KICK: assert property (@(posedge clk) disable iff (!quiet)
    (kick_bad && !wr_cmd && !rst_req) |=> (rst_req && cause == C_KICK)); // R4
  AST_NO_IDLE_TMO: assert property (@(posedge clk) disable iff (!quiet)
    (rst_req && cause == C_TMO) |-> $past(running)); // R9
  AST_CAUSE_KEEP: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (!rst_req && $past(user_rst_n)) |-> $stable(cause)); // R8
  AST_SVC_RESTART: assert property (@(posedge clk) disable iff (!quiet)
    svb_ok |=> cnt == '0); // R3
endmodule

// File: tb/wdg_magic_kick_test.sv
`timescale 1ns/1ps
module wdg_magic_kick_test;
  localparam logic [3:0] A_CMD = 4'h0, A_CFG = 4'h4, A_SVA = 4'h8, A_SVB = 4'hC;
  localparam logic [31:0] KA = 32'hABCD1234, KB = 32'h4321DCBA, EN = 32'h8000_0000;

  logic clk = 1'b0, hard_rst_n = 1'b0, sys_rst_n = 1'b1, user_rst_n = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rst_req;
  int tests = 0, fails = 0, pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdg_magic_kick uut (.clk(clk), .hard_rst_n(hard_rst_n), .sys_rst_n(sys_rst_n),
    .user_rst_n(user_rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req));

  always @(negedge clk) if (rst_req) pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_wd(input logic [4:0] dly);
    wr(A_CFG, {27'd0, dly});
    wr(A_SVA, KA);
    wr(A_SVB, KB);
  endtask

  function automatic logic [2:0] exp_code(input int op, input logic [31:0] d);
    case (op)
      0: return 3'd0;
      1, 2, 3: return 3'd2;
      default: return d[0] ? 3'd3 : 3'd0;
    endcase
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    int p0;
    void'($urandom(32'd20240611));
    idle(3);
    hard_rst_n = 1'b1;
    idle(1);

    rd(A_CFG, v); check("R1 cfg after reset", v, 0);
    rd(A_SVA, v); check("R8 cause after hard reset", v, 0);
    check("R9 no req at reset", rst_req, 0);
    p0 = pulses; idle(100);
    check("R9 no pulse while stopped", pulses, p0);
    wr(A_CFG, 32'h0000_0015);
    rd(A_CFG, v); check("R1 cfg readback", v, 32'h15);
    rd(A_CMD, v); check("R1 cmd reads zero", v, 0);

    // R2: d=2, period 8
    wr(A_CFG, EN | 32'd2);
    idle(7); check("R2 no pulse before period", rst_req, 0);
    idle(1); check("R2 pulse at period", rst_req, 1);
    rd(A_SVA, v); check("R2 cause timeout", v, 1);
    idle(1); check("R2 single cycle pulse", rst_req, 0);
    stop_wd(5'd2);
    p0 = pulses; idle(40);
    check("R5 stopped after disable and service", pulses, p0);

    // R5: disable does not stop until a service
    wr(A_CFG, EN | 32'd2);
    wr(A_CFG, 32'd2);
    idle(6); check("R5 still counting", rst_req, 0);
    idle(1); check("R5 expiry after disable", rst_req, 1);
    wr(A_SVA, KA); wr(A_SVB, KB);
    p0 = pulses; idle(40);
    check("R5 service completes stop", pulses, p0);

    // R3: d=3, period 16, service mid-way
    wr(A_CFG, EN | 32'd3);
    idle(8);
    wr(A_SVA, KA); wr(A_SVB, KB);
    p0 = pulses;
    idle(15); check("R3 no pulse after service", rst_req, 0);
    check("R3 original expiry cancelled", pulses, p0);
    idle(1); check("R3 pulse one period after service", rst_req, 1);
    stop_wd(5'd3);

    // R7: exponent change while running
    wr(A_CFG, EN | 32'd2);
    wr(A_CFG, EN | 32'd4);
    idle(6); check("R7 old period holds", rst_req, 0);
    idle(1); check("R7 expiry at old period", rst_req, 1);
    idle(31); check("R7 new period not early", rst_req, 0);
    idle(1); check("R7 expiry at new period", rst_req, 1);
    stop_wd(5'd4);

    // R10: service exactly on expiry edge, then bad kick on expiry edge
    wr(A_CFG, EN | 32'd2);
    wr(A_SVA, KA);
    idle(6);
    wr(A_SVB, KB);
    check("R10 service cancels expiry", rst_req, 0);
    idle(7); check("R10 no early pulse", rst_req, 0);
    idle(1); check("R10 expiry after service", rst_req, 1);
    idle(7);
    wr(A_SVB, KB);
    check("R10 bad kick on expiry edge", rst_req, 1);
    rd(A_SVA, v); check("R10 cause is kick fault", v, 2);
    stop_wd(5'd31);
    idle(1);

    // R4 / R6 random kick and command traffic
    for (int i = 0; i < 40; i++) begin
      int op;
      logic [31:0] d;
      logic [2:0] c;
      op = int'($urandom % 5);
      d = $urandom;
      case (op)
        0: begin wr(A_SVA, KA); wr(A_SVB, KB); end
        1: begin if (d == KA) d = ~d; wr(A_SVA, d); end
        2: begin d = KB; wr(A_SVB, d); end
        3: begin if (d == KB) d = ~d; wr(A_SVA, KA); wr(A_SVB, d); end
        default: wr(A_CMD, d);
      endcase
      c = exp_code(op, d);
      check((op == 4) ? "R6 command request" : "R4 kick request", rst_req, (c != 0));
      if (c != 0) begin
        rd(A_SVA, v); check((op == 4) ? "R6 cause soft" : "R4 cause kick", v, c);
      end
      idle(1);
    end

    // R8: cause retention across resets
    wr(A_CMD, 32'd1);
    check("R6 directed command", rst_req, 1);
    wr(A_CMD, 32'd0);
    check("R6 bit0 clear ignored", rst_req, 0);
    wr(A_CFG, EN | 32'd7);
    sys_rst_n = 1'b0; idle(2); sys_rst_n = 1'b1; idle(1);
    rd(A_SVA, v); check("R8 cause kept over system reset", v, 3);
    rd(A_CFG, v); check("R8 config cleared by system reset", v, 0);
    user_rst_n = 1'b0; idle(1); user_rst_n = 1'b1; idle(1);
    rd(A_SVA, v); check("R8 user reset cause", v, 4);
    hard_rst_n = 1'b0; idle(1); hard_rst_n = 1'b1; idle(1);
    rd(A_SVA, v); check("R8 hard reset clears cause", v, 0);

    finish_up();
  end
endmodule